// File: doc/BRIEF.md
# SATA Out-of-Band Sequence Detector

This block recognises the out-of-band signalling sequences that a SATA link uses to initialise and wake itself. It takes a single signal-present level from an external analog squelch comparator and divides the reference clock down to a squelch sampling strobe. At every strobe it measures how long the line has been in its present state. When the line changes state, the run that just ended is judged. A burst is valid when its length falls inside a programmable window. A gap is classified as a reset/initialisation idle, a wake idle, or invalid.

The detector counts valid bursts and valid idles of one kind. It fires a single-cycle pulse on `det_init` or `det_wake` once both counts reach their programmed thresholds, then starts again from nothing. All windows and thresholds are runtime inputs, so firmware can retune them for a different squelch rate.

Top module: `oob_seq_detect`

## Requirements
- R1: `sq_tick` is high for one clock in every N clocks, where `div_sel` value 0 gives N=1 and a value s from 1 to 7 gives N=2*s (2, 4, 6, ... 14).
- R2: The squelch level passes through a two-flop synchronizer and is then sampled only on `sq_tick`. Run lengths count strobes and saturate at 63, so a run of 64 or more strobes is judged as 63 and never wraps to a small value.
- R3: A burst is valid when `cfg_burst_min <= length <= cfg_burst_max`, both ends included. Any other burst clears the burst and idle counts and returns to waiting.
- R4: An idle whose length lies in `[cfg_init_min, cfg_init_max]` is an initialisation idle. Otherwise, one whose length lies in `[cfg_wake_min, cfg_wake_max]` is a wake idle. Any other idle seen while counting clears both counts and returns to waiting.
- R5: While waiting (burst count zero), idles are ignored whatever their length, and the first valid burst starts counting.
- R6: A valid idle of the kind being counted increments the idle count. A valid idle of the other kind restarts the idle count at one, switches the counted kind, and keeps the burst count.
- R7: After each valid event, if the burst count is at least `cfg_burst_num` and the idle count is at least `cfg_idle_num`, the pulse for the counted idle kind fires on the next clock. All counts then clear. A threshold of 0 acts as 1, and the 3-bit counts saturate at 7.
- R8: Each detection pulse is high for exactly one clock, even when the squelch strobe is divided, and `det_init` and `det_wake` are never high together.
- R9: During and right after a synchronous reset, `det_init`, `det_wake` and `sq_tick` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Squelch divider select (0 gives 1, s gives 2*s) |
| sq_present | input | 1 | Asynchronous squelch comparator level, 1 = burst |
| cfg_burst_num | input | 3 | Bursts required for a match |
| cfg_idle_num | input | 3 | Same-kind idles required for a match |
| cfg_burst_min | input | 6 | Shortest valid burst, in strobes |
| cfg_burst_max | input | 6 | Longest valid burst, in strobes |
| cfg_init_min | input | 6 | Shortest initialisation idle |
| cfg_init_max | input | 6 | Longest initialisation idle |
| cfg_wake_min | input | 6 | Shortest wake idle |
| cfg_wake_max | input | 6 | Longest wake idle |
| sq_tick | output | 1 | Squelch sampling strobe |
| det_init | output | 1 | One-clock pulse: initialisation/reset sequence found |
| det_wake | output | 1 | One-clock pulse: wake sequence found |

## Verification
Two functions can meet in the same cycle. The first is the idle event that switches the counted kind, which restarts the idle count. The second is the threshold comparison, which decides a match from that same event. The bench provokes this with mixed sequences, such as one wake idle followed by three initialisation idles, or wake, wake, init, wake, wake. It judges the result by the number and kind of pulses counted after each sequence. A second collision happens when the fourth burst completes a match on the same event that the burst counter saturates or advances on. Sequences longer than the threshold check that the clear wins and that the trailing bursts of the same train produce no second pulse.

// File: rtl/oob_pkg.sv
package oob_pkg;
  localparam int LEN_W = 6;
  localparam int CNT_W = 3;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    IDLE_NONE = 2'd0,
    IDLE_INIT = 2'd1,
    IDLE_WAKE = 2'd2
  } idle_kind_e;

  typedef struct packed {
    logic [CNT_W-1:0] n_burst;
    logic [CNT_W-1:0] n_idle;
    logic [LEN_W-1:0] b_min;
    logic [LEN_W-1:0] b_max;
    logic [LEN_W-1:0] i_min;
    logic [LEN_W-1:0] i_max;
    logic [LEN_W-1:0] w_min;
    logic [LEN_W-1:0] w_max;
  } oob_cfg_t;
endpackage

// File: rtl/oob_clk_div.sv
module oob_clk_div #(
  parameter int SEL_W = 3,
  localparam int DIV_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb begin
    if (sel == '0) lim = DIV_W'(1);
    else           lim = {sel, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  // R1: with a ratio of two or more, strobes never come back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != '0 && $stable(sel)) |=> !tick);
endmodule

// File: rtl/oob_sync.sv
module oob_sync (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d_async;
      q    <= meta;
    end
  end
endmodule

// File: rtl/oob_run_len.sv
module oob_run_len #(
  parameter int LEN_W = 6,
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             level,
  output logic             ev_valid,
  output logic             ev_burst,
  output logic [LEN_W-1:0] ev_len
);
  logic             cur_lvl;
  logic [LEN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl  <= 1'b0;
      run      <= LEN_W'(1);
      ev_valid <= 1'b0;
      ev_burst <= 1'b0;
      ev_len   <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (tick) begin
        if (level == cur_lvl) begin
          if (run != LEN_MAX) run <= run + LEN_W'(1);
        end else begin
          ev_valid <= 1'b1;
          ev_burst <= cur_lvl;
          ev_len   <= run;
          cur_lvl  <= level;
          run      <= LEN_W'(1);
        end
      end
    end
  end

  // R2: a reported run is never empty (a saturated run never wraps to zero)
  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> ev_len != '0);

  // R2: events only arise from a squelch strobe
  assert_event_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $past(tick));
endmodule

// File: rtl/oob_seq_fsm.sv
module oob_seq_fsm
  import oob_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  oob_cfg_t         cfg,
  input  logic             ev_valid,
  input  logic             ev_burst,
  input  logic [LEN_W-1:0] ev_len,
  output logic             det_init,
  output logic             det_wake
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic {ST_WAIT = 1'b0, ST_RUN = 1'b1} st_e;

  st_e              st, st_n;
  logic [CNT_W-1:0] bcnt, bcnt_n, icnt, icnt_n;
  idle_kind_e       kind, kind_n, ev_kind;
  logic [CNT_W-1:0] thr_b, thr_i;
  logic             burst_ok, bad, match;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_W'(1);
  endfunction

  always_comb begin
    thr_b    = (cfg.n_burst == '0) ? CNT_W'(1) : cfg.n_burst;
    thr_i    = (cfg.n_idle  == '0) ? CNT_W'(1) : cfg.n_idle;
    burst_ok = (ev_len >= cfg.b_min) && (ev_len <= cfg.b_max);
    if ((ev_len >= cfg.i_min) && (ev_len <= cfg.i_max))      ev_kind = IDLE_INIT;
    else if ((ev_len >= cfg.w_min) && (ev_len <= cfg.w_max)) ev_kind = IDLE_WAKE;
    else                                                     ev_kind = IDLE_NONE;
  end

  always_comb begin
    st_n   = st;
    bcnt_n = bcnt;
    icnt_n = icnt;
    kind_n = kind;
    bad    = 1'b0;
    if (ev_valid) begin
      if (ev_burst) begin
        if (burst_ok) begin
          bcnt_n = sat_inc(bcnt);
          st_n   = ST_RUN;
        end else begin
          bad = 1'b1;
        end
      end else if (st == ST_RUN) begin
        if (ev_kind == IDLE_NONE) begin
          bad = 1'b1;
        end else if (ev_kind == kind) begin
          icnt_n = sat_inc(icnt);
        end else begin
          icnt_n = CNT_W'(1);
          kind_n = ev_kind;
        end
      end
    end
    match = ev_valid && !bad && (st_n == ST_RUN) &&
            (bcnt_n >= thr_b) && (icnt_n >= thr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_WAIT;
      bcnt     <= '0;
      icnt     <= '0;
      kind     <= IDLE_NONE;
      det_init <= 1'b0;
      det_wake <= 1'b0;
    end else begin
      det_init <= 1'b0;
      det_wake <= 1'b0;
      if (bad || match) begin
        st   <= ST_WAIT;
        bcnt <= '0;
        icnt <= '0;
        kind <= IDLE_NONE;
        if (match) begin
          det_init <= (kind_n == IDLE_INIT);
          det_wake <= (kind_n == IDLE_WAKE);
        end
      end else begin
        st   <= st_n;
        bcnt <= bcnt_n;
        icnt <= icnt_n;
        kind <= kind_n;
      end
    end
  end

  // R8: the two detection outputs are mutually exclusive
  assert_det_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(det_init && det_wake));

  // R8: each pulse lasts one clock
  assert_init_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    det_init |=> !det_init);
  assert_wake_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    det_wake |=> !det_wake);

  // R7: a pulse follows a measurement event and leaves the counts cleared
  assert_det_after_event_R7: assert property (@(posedge clk) disable iff (rst)
    (det_init || det_wake) |-> ($past(ev_valid) && bcnt == '0 && icnt == '0));

  // R5: an idle seen while waiting changes nothing
  assert_wait_ignores_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && ev_valid && !ev_burst) |=> (st == ST_WAIT && bcnt == '0));

  // R7: the burst count saturates rather than wrapping
  assert_bcnt_saturate_R7: assert property (@(posedge clk) disable iff (rst)
    (bcnt == CNT_MAX && ev_valid && ev_burst) |=> (bcnt == CNT_MAX || bcnt == '0));
endmodule

// File: rtl/oob_seq_detect.sv
module oob_seq_detect
  import oob_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             sq_present,
  input  logic [CNT_W-1:0] cfg_burst_num,
  input  logic [CNT_W-1:0] cfg_idle_num,
  input  logic [LEN_W-1:0] cfg_burst_min,
  input  logic [LEN_W-1:0] cfg_burst_max,
  input  logic [LEN_W-1:0] cfg_init_min,
  input  logic [LEN_W-1:0] cfg_init_max,
  input  logic [LEN_W-1:0] cfg_wake_min,
  input  logic [LEN_W-1:0] cfg_wake_max,
  output logic             sq_tick,
  output logic             det_init,
  output logic             det_wake
);
  logic             sq_sync;
  logic             ev_valid, ev_burst;
  logic [LEN_W-1:0] ev_len;
  oob_cfg_t         cfg;

  always_comb begin
    cfg.n_burst = cfg_burst_num;
    cfg.n_idle  = cfg_idle_num;
    cfg.b_min   = cfg_burst_min;
    cfg.b_max   = cfg_burst_max;
    cfg.i_min   = cfg_init_min;
    cfg.i_max   = cfg_init_max;
    cfg.w_min   = cfg_wake_min;
    cfg.w_max   = cfg_wake_max;
  end

  oob_clk_div #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .sel(div_sel), .tick(sq_tick)
  );

  oob_sync u_sync (
    .clk(clk), .rst(rst), .d_async(sq_present), .q(sq_sync)
  );

  oob_run_len #(.LEN_W(LEN_W)) u_run (
    .clk(clk), .rst(rst), .tick(sq_tick), .level(sq_sync),
    .ev_valid(ev_valid), .ev_burst(ev_burst), .ev_len(ev_len)
  );

  oob_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .cfg(cfg),
    .ev_valid(ev_valid), .ev_burst(ev_burst), .ev_len(ev_len),
    .det_init(det_init), .det_wake(det_wake)
  );
endmodule

// File: tb/oob_seq_detect_tb.sv
module oob_seq_detect_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] div_sel = 3'd0;
  logic       sq_present = 1'b0;
  logic [2:0] cfg_burst_num, cfg_idle_num;
  logic [5:0] cfg_burst_min, cfg_burst_max, cfg_init_min, cfg_init_max;
  logic [5:0] cfg_wake_min, cfg_wake_max;
  logic       sq_tick, det_init, det_wake;

  int checks = 0, failures = 0;
  int n_init = 0, n_wake = 0, n_both = 0, n_ticks = 0;
  int ratio = 1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oob_seq_detect u_dut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .sq_present(sq_present),
    .cfg_burst_num(cfg_burst_num), .cfg_idle_num(cfg_idle_num),
    .cfg_burst_min(cfg_burst_min), .cfg_burst_max(cfg_burst_max),
    .cfg_init_min(cfg_init_min), .cfg_init_max(cfg_init_max),
    .cfg_wake_min(cfg_wake_min), .cfg_wake_max(cfg_wake_max),
    .sq_tick(sq_tick), .det_init(det_init), .det_wake(det_wake)
  );

  // high-cycle counters: equal pulse count and high-cycle count means one-clock pulses
  always @(negedge clk) begin
    if (!rst) begin
      n_init  += int'(det_init);
      n_wake  += int'(det_wake);
      n_both  += int'(det_init & det_wake);
      n_ticks += int'(sq_tick);
    end
  end

  // columns: bursts, burst length, gap0..gap5, expected init, expected wake
  localparam int NV = 13;
  localparam int VEC [NV][10] = '{
    '{4, 5, 16, 16, 16,  0,  0,  0, 1, 0},  // R7 init train
    '{4, 5,  6,  6,  6,  0,  0,  0, 0, 1},  // R7 wake train
    '{4, 5, 16,  6, 16,  0,  0,  0, 0, 0},  // R6 kind switch restarts
    '{4, 8, 16, 16, 16,  0,  0,  0, 0, 0},  // R3 burst too long
    '{4, 3, 16, 16, 16,  0,  0,  0, 0, 0},  // R3 burst too short
    '{4, 4, 12, 22, 12,  0,  0,  0, 1, 0},  // R3 R4 inclusive edges
    '{4, 7,  4,  7,  4,  0,  0,  0, 0, 1},  // R3 R4 inclusive edges
    '{4, 5, 16, 23, 16,  0,  0,  0, 0, 0},  // R4 above init window
    '{4, 5,  6,  3,  6,  0,  0,  0, 0, 0},  // R4 below wake window
    '{5, 5,  6, 16, 16, 16,  0,  0, 1, 0},  // R6 wake then three inits
    '{7, 5, 16, 16, 16, 16, 16, 16, 1, 0},  // R7 clear after match
    '{4, 5, 16, 10, 16,  0,  0,  0, 0, 0},  // R4 gap between windows
    '{6, 5,  6,  6, 16,  6,  6,  0, 0, 0}   // R6 repeated restarts
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic seg(input bit v, input int n);
    sq_present = v;
    repeat (n * ratio) @(negedge clk);
  endtask

  task automatic set_defaults();
    cfg_burst_num = 3'd4; cfg_idle_num = 3'd3;
    cfg_burst_min = 6'd4; cfg_burst_max = 6'd7;
    cfg_init_min  = 6'd12; cfg_init_max = 6'd22;
    cfg_wake_min  = 6'd4;  cfg_wake_max = 6'd7;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int si, sw, sh;
    set_defaults();
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(det_init == 1'b0 && det_wake == 1'b0, "R9 detect low in reset", int'(det_init | det_wake), 0);
    chk(sq_tick == 1'b0, "R9 tick low in reset", int'(sq_tick), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(det_init == 1'b0 && det_wake == 1'b0, "R9 detect low after reset", int'(det_init | det_wake), 0);
    repeat (3) @(negedge clk);
    chk(sq_tick == 1'b1, "R1 undivided strobe every clock", int'(sq_tick), 1);
    seg(0, 40);

    for (int v = 0; v < NV; v++) begin
      si = n_init; sw = n_wake;
      for (int b = 0; b < VEC[v][0]; b++) begin
        seg(1, VEC[v][1]);
        if (b < VEC[v][0] - 1) seg(0, VEC[v][2 + b]);
      end
      seg(0, 40);
      chk(n_init - si == VEC[v][8], $sformatf("R7 vector %0d init pulses", v), n_init - si, VEC[v][8]);
      chk(n_wake - sw == VEC[v][9], $sformatf("R7 vector %0d wake pulses", v), n_wake - sw, VEC[v][9]);
    end

    // R1 divider ratios
    for (int s = 1; s < 8; s += 2) begin
      int t0;
      div_sel = 3'(s);
      repeat (40) @(negedge clk);
      t0 = n_ticks;
      repeat (10 * 2 * s) @(negedge clk);
      chk(n_ticks - t0 == 10, $sformatf("R1 ratio for select %0d", s), n_ticks - t0, 10);
    end

    // R8 divided operation: one-clock pulse per match
    div_sel = 3'd2; ratio = 4;
    repeat (20) @(negedge clk);
    seg(0, 40);
    si = n_init; sh = n_both;
    for (int b = 0; b < 4; b++) begin
      seg(1, 5);
      if (b < 3) seg(0, 16);
    end
    seg(0, 40);
    chk(n_init - si == 1, "R8 divided init pulse one clock", n_init - si, 1);
    chk(n_both - sh == 0, "R8 outputs never together", n_both - sh, 0);
    div_sel = 3'd0; ratio = 1;
    repeat (20) @(negedge clk);
    seg(0, 40);

    // R2 saturation: a 68-strobe burst must not wrap to a valid length
    si = n_init;
    seg(1, 68); seg(0, 16);
    for (int b = 0; b < 3; b++) begin
      seg(1, 5);
      if (b < 2) seg(0, 16);
    end
    seg(0, 40);
    chk(n_init - si == 0, "R2 saturated burst rejected", n_init - si, 0);

    // R7 custom thresholds: two bursts, one idle
    cfg_burst_num = 3'd2; cfg_idle_num = 3'd1;
    si = n_init;
    seg(1, 5); seg(0, 16); seg(1, 5); seg(0, 40);
    chk(n_init - si == 1, "R7 thresholds two and one", n_init - si, 1);

    // R7 zero thresholds act as one
    cfg_burst_num = 3'd0; cfg_idle_num = 3'd0;
    sw = n_wake;
    seg(1, 5); seg(0, 6); seg(1, 5); seg(0, 40);
    chk(n_wake - sw == 1, "R7 zero thresholds act as one", n_wake - sw, 1);

    // R5 idle while waiting is ignored
    cfg_burst_num = 3'd1; cfg_idle_num = 3'd1;
    si = n_init; sw = n_wake;
    seg(1, 10); seg(0, 6); seg(1, 5); seg(0, 16); seg(1, 5); seg(0, 40);
    chk(n_init - si == 1, "R5 waiting idle ignored (init)", n_init - si, 1);
    chk(n_wake - sw == 0, "R5 waiting idle ignored (wake)", n_wake - sw, 0);

    chk(n_both == 0, "R8 exclusive over whole run", n_both, 0);
    finish_run();
  end
endmodule